// File: doc/BRIEF.md
# Link Integrity Monitor

This block decides whether a 100 Mbps link is usable. It watches a qualified-signal indication from the receive front end, `data_valid`. It counts millisecond ticks while that indication stays high. Once the line has been stable for the settling time, it declares the link. When auto-negotiation is in use, the block first parks in a ready state and waits for a permit from the negotiation logic. When auto-negotiation is off, it goes straight to the up state. The up state also enables the transmit and receive datapaths.

A drop of `data_valid` tears the link down in the same cycle, and the state machine returns to the down state at the next clock. A path select can route an external 10 Mbps link indication to `link_status` in place of the 100 Mbps result. The settling length is the parameter `SETTLE_MS`, which defaults to 330 ticks.

Top module: `link_monitor`

## Requirements
- R1: After reset, `state_code` is 0 (down), and `link_status` and `tx_rx_enable` are low while `sel_10m` is low.
- R2: The block leaves the down state only after `SETTLE_MS` cycles with `ms_tick` high, all counted while `data_valid` stays high. Clock cycles without a tick do not count. Any cycle with `data_valid` low discards the count.
- R3: With `an_enable` high, a qualified line moves the block from down to ready (`state_code` 1). It stays in ready while `an_link_permit` is low, and moves to up (`state_code` 2) on the clock after the permit is seen.
- R4: With `an_enable` low, a qualified line moves the block from down directly to up, without passing through ready.
- R5: When `data_valid` is low, the 100 Mbps link result and `tx_rx_enable` are low in that same cycle. `state_code` is 0 after the next clock, whatever the previous state was.
- R6: `tx_rx_enable` is high only while `state_code` is 2 (up) and `data_valid` is high.
- R7: While `sel_10m` is high, `link_status` equals `link_10m`. While `sel_10m` is low, `link_status` is high exactly when the state is up and `data_valid` is high.
- R8: `state_code` uses only the values 0 (down), 1 (ready) and 2 (up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_valid | input | 1 | Receive front end reports a valid line signal |
| an_enable | input | 1 | Auto-negotiation in use |
| an_link_permit | input | 1 | Auto-negotiation allows link up |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sel_10m | input | 1 | Select the 10 Mbps link path |
| link_10m | input | 1 | Link indication from the 10 Mbps receiver |
| link_status | output | 1 | Link indication |
| tx_rx_enable | output | 1 | Enables the transmit and receive datapaths |
| state_code | output | 2 | 0 down, 1 ready, 2 up |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse and that all inputs are synchronous to `clk`. They make no assumption about how often ticks arrive. The stimulus changes inputs only on falling edges and keeps ticks one cycle wide. It uses a settling length of 3, which exercises the qualification window and lets the checker count the window without a deep history.

// File: rtl/link_monitor.sv
module link_monitor #(
  parameter int SETTLE_MS = 330
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_valid,
  input  logic       an_enable,
  input  logic       an_link_permit,
  input  logic       ms_tick,
  input  logic       sel_10m,
  input  logic       link_10m,
  output logic       link_status,
  output logic       tx_rx_enable,
  output logic [1:0] state_code
);
  localparam int CW = $clog2(SETTLE_MS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_MS);

  typedef enum logic [1:0] {DOWN = 2'd0, READY = 2'd1, UP = 2'd2} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt;
  logic          settled, up_ok;

  assign settled = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !data_valid) cnt <= '0;
    else if (ms_tick && !settled) cnt <= cnt + 1'b1;
  end

  always_comb begin
    st_nx = st;
    if (!data_valid) st_nx = DOWN;
    else begin
      case (st)
        DOWN:    if (settled) st_nx = an_enable ? READY : UP;
        READY:   if (an_link_permit || !an_enable) st_nx = UP;
        UP:      st_nx = UP;
        default: st_nx = DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= DOWN;
    else st <= st_nx;
  end

  assign up_ok        = (st == UP) && data_valid;
  assign tx_rx_enable = up_ok;
  assign link_status  = sel_10m ? link_10m : up_ok;
  assign state_code   = st;
endmodule

module link_monitor_chk #(
  parameter int SETTLE_MS = 330
) (
  input logic       clk,
  input logic       rst_n,
  input logic       data_valid,
  input logic       an_enable,
  input logic       an_link_permit,
  input logic       ms_tick,
  input logic       sel_10m,
  input logic       link_10m,
  input logic       link_status,
  input logic       tx_rx_enable,
  input logic [1:0] state_code
);
  int unsigned seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !data_valid) seen <= 0;
    else if (ms_tick && seen < SETTLE_MS) seen <= seen + 1;
  end

  // R2
  early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd0 && seen < SETTLE_MS) |=> state_code == 2'd0);
  // R3
  permit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd1 && an_enable && !an_link_permit) |=> state_code != 2'd2);
  // R4
  skip_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd0 && !an_enable) |=> state_code != 2'd1);
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |=> state_code == 2'd0);
  // R6
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rx_enable |-> (state_code == 2'd2 && data_valid));
  // R7
  path_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_10m |-> link_status == link_10m);
  // R8
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 2'd3);
endmodule

bind link_monitor link_monitor_chk #(.SETTLE_MS(SETTLE_MS)) u_chk (.*);

// File: tb/test_link_monitor.sv
module test_link_monitor;
  logic clk = 0, rst_n = 0;
  logic data_valid = 0, an_enable = 0, an_link_permit = 0, ms_tick = 0;
  logic sel_10m = 0, link_10m = 0;
  logic link_status, tx_rx_enable;
  logic [1:0] state_code;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  link_monitor #(.SETTLE_MS(3)) i_link_monitor (.*);

  // {dv, an, permit, tick, sel10, link10, exp_link, exp_txrx, exp_state[1:0]}
  localparam logic [9:0] VEC [21] = '{
    10'b1101_00_00_00, 10'b1101_00_00_00, 10'b1101_00_00_00, // R2 counting
    10'b1101_00_00_01,                                       // R3 ready
    10'b1100_00_00_01,                                       // R3 hold
    10'b1110_00_11_10,                                       // R3 up
    10'b0000_00_00_00,                                       // R5 drop
    10'b1001_00_00_00, 10'b1001_00_00_00, 10'b1001_00_00_00,
    10'b1000_00_11_10,                                       // R4 direct up
    10'b1000_10_01_10,                                       // R7 10M low
    10'b1000_11_11_10,                                       // R7 10M high
    10'b1000_00_11_10,
    10'b0000_00_00_00,                                       // R5
    10'b1000_00_00_00, 10'b1000_00_00_00,                    // R2 no ticks
    10'b1001_00_00_00, 10'b1001_00_00_00, 10'b1001_00_00_00,
    10'b1000_00_11_10                                        // R2/R4
  };

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic dv, logic an, logic pm, logic tk);
    @(negedge clk);
    data_valid = dv; an_enable = an; an_link_permit = pm; ms_tick = tk;
    @(posedge clk); #1;
  endtask

  task automatic outs(string req, logic l, logic t, logic [1:0] s);
    chk(req, {link_status, tx_rx_enable, state_code}, {l, t, s});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; data_valid = 0; ms_tick = 0;
    sel_10m = 0; link_10m = 0;
    @(posedge clk); #1; @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    outs("R1", 0, 0, 2'd0);
    sel_10m = 1; link_10m = 1; #1;
    outs("R7", 1, 0, 2'd0);
    sel_10m = 0; link_10m = 0;

    foreach (VEC[i]) begin
      @(negedge clk);
      {data_valid, an_enable, an_link_permit, ms_tick, sel_10m, link_10m} = VEC[i][9:4];
      @(posedge clk); #1;
      chk($sformatf("R2-R7 vector %0d", i), {link_status, tx_rx_enable, state_code}, VEC[i][3:0]);
    end

    // R5: same-cycle drop before any clock edge
    @(negedge clk); data_valid = 0; #1;
    outs("R5", 0, 0, 2'd2);
    @(posedge clk); #1;
    outs("R5", 0, 0, 2'd0);

    // R2: interruption discards the count
    step(1, 1, 0, 1); step(1, 1, 0, 1);
    step(0, 1, 0, 0);
    step(1, 1, 0, 1); step(1, 1, 0, 1);
    outs("R2", 0, 0, 2'd0);
    step(1, 1, 0, 1); step(1, 1, 0, 0);
    outs("R3", 0, 0, 2'd1);

    // R5 from ready
    step(0, 1, 0, 0);
    outs("R5", 0, 0, 2'd0);

    // R1: reset from up
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 0, 0, 0);
    outs("R6", 1, 1, 2'd2);
    do_reset();
    data_valid = 1; #1;
    outs("R1", 0, 0, 2'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule